// File: doc/BRIEF.md
# Serial Length-Code Loader

This block configures the length of a line delay through a three-wire serial port. A shift clock samples a serial data pin into an 11-bit shift register, most significant bit first. A separate latch-enable strobe then copies the whole register in one step into a set register. The shift clock and strobe are unrelated to the delay clock. The set register therefore reaches the delay-clock domain through a toggle handshake. A multi-flop synchroniser carries the toggle, and the code word is captured only after the toggle has settled, so the delay line never sees a partly updated code.

A select pin chooses where the code comes from. When it is high, an 11-bit parallel code bus sets the length. When it is low, the serially loaded code sets it and the parallel bus is ignored. The block outputs the selected code and the resulting delay length, which is the code plus a fixed base of 31 cycles. The delay memory itself is outside this block.

Top module: `serial_len_loader`

## Requirements
- R1: After reset, `len_code` is 0, `delay_len` is 31 and `code_upd` is low, with serial mode selected.
- R2: Each rising edge of `sclk` shifts `sdata` into the shift register at bit 0 and moves older bits up one place. After 11 shifts, the first bit sent sits in bit 10, which is the most significant.
- R3: When more than 11 bits are shifted before a latch, only the last 11 are kept.
- R4: A rising edge of `latch_en` copies the shift register into the set register. Shifting without a latch strobe leaves `len_code` unchanged.
- R5: A latched code appears on `len_code` at the third rising edge of `clk` after the `latch_en` rising edge. When the strobe falls close to a `clk` edge, this may be one edge later.
- R6: Each latch strobe produces exactly one `code_upd` pulse, one `clk` cycle wide, on the same edge that the serial code changes.
- R7: While `par_sel` is high, `len_code` equals the value `par_code` had at the previous `clk` edge. The select passes through a two-stage synchroniser before it takes effect.
- R8: While `par_sel` is low, changes on `par_code` have no effect on `len_code`.
- R9: `delay_len` equals `len_code` + 31. This spans 31 for code 0 up to 2078 for code 2047.
- R10: A latch strobe issued in parallel mode still updates the stored serial code. That code appears on `len_code` once serial mode is selected again.
- R11: The serial code seen in the `clk` domain changes only on a `code_upd` edge, with all 11 bits changing together. Until that edge, the previous code is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Delay clock |
| rst_n | input | 1 | Asynchronous active-low reset, all domains |
| sclk | input | 1 | Serial shift clock, rising edge active |
| sdata | input | 1 | Serial code data, most significant bit first |
| latch_en | input | 1 | Rising edge copies the shift register into the set register |
| par_sel | input | 1 | 1 = parallel code bus, 0 = serial code |
| par_code | input | 11 | Parallel length code |
| len_code | output | 11 | Selected length code, `clk` domain |
| delay_len | output | 12 | Delay length in cycles (code + 31) |
| code_upd | output | 1 | One-cycle pulse when a new serial code lands |

## Verification
A serial code is due on `len_code` and `code_upd` exactly three `clk` rising edges after the strobe. A parallel code follows `par_code` one edge later. A change of `par_sel` settles after two edges. The bench raises every strobe just after a falling edge of `clk`, where no setup race exists. It then records the `clk` edge count at which the result is due. A monitor samples on falling edges and compares both the value and the arrival edge of each pulse against the queued expectation. One edge before each due edge, the bench also confirms that the previous code is still held.

// File: rtl/sll_pkg.sv
package sll_pkg;

  typedef enum logic {
    SRC_SERIAL   = 1'b0,
    SRC_PARALLEL = 1'b1
  } code_src_e;

endpackage

// File: rtl/sll_shift_capture.sv
module sll_shift_capture #(
  parameter int CODE_W = 11
) (
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sdata,
  input  logic              latch_en,
  output logic [CODE_W-1:0] set_code,
  output logic              set_tog
);

  logic [CODE_W-1:0] shift_q;

  // Serial shift, newest bit at position 0; older bits fall off the top.
  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= {shift_q[CODE_W-2:0], sdata};
  end

  // Parallel transfer on the strobe edge, with a toggle announcing it.
  always_ff @(posedge latch_en or negedge rst_n) begin
    if (!rst_n) begin
      set_code <= '0;
      set_tog  <= 1'b0;
    end else begin
      set_code <= shift_q;
      set_tog  <= ~set_tog;
    end
  end

  p_shift_order_r2: assert property (@(posedge sclk) disable iff (!rst_n)
    1'b1 |=> shift_q[CODE_W-1:1] == $past(shift_q[CODE_W-2:0]));

endmodule

// File: rtl/sll_code_sync.sv
module sll_code_sync #(
  parameter int CODE_W      = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] set_code,
  input  logic              set_tog,
  output logic [CODE_W-1:0] code_q,
  output logic              upd_q
);

  logic sync_q [SYNC_STAGES];
  logic tog_seen;
  logic upd_event;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q[0] <= 1'b0;
    else        sync_q[0] <= set_tog;
  end

  for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[g] <= 1'b0;
      else        sync_q[g] <= sync_q[g-1];
    end
  end

  // A settled toggle that differs from the last one seen marks a new code.
  assign upd_event = sync_q[SYNC_STAGES-1] ^ tog_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_seen <= 1'b0;
      code_q   <= '0;
      upd_q    <= 1'b0;
    end else begin
      tog_seen <= sync_q[SYNC_STAGES-1];
      upd_q    <= upd_event;
      if (upd_event) code_q <= set_code;
    end
  end

  p_no_tear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code_q) |-> upd_q);

  p_upd_onepulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |=> !upd_q);

endmodule

// File: rtl/sll_mode_mux.sv
module sll_mode_mux
  import sll_pkg::*;
#(
  parameter int CODE_W      = 11,
  parameter int BASE_DELAY  = 31,
  parameter int SYNC_STAGES = 2,
  parameter int DLY_W       = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              par_sel,
  input  logic [CODE_W-1:0] par_code,
  input  logic [CODE_W-1:0] ser_code,
  input  logic              ser_upd,
  output logic [CODE_W-1:0] len_code,
  output logic [DLY_W-1:0]  delay_len
);

  logic        sel_q [SYNC_STAGES];
  logic [CODE_W-1:0] par_q;
  code_src_e   src;

  function automatic logic [DLY_W-1:0] code_to_delay(input logic [CODE_W-1:0] c);
    return DLY_W'(c) + DLY_W'(BASE_DELAY);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q[0] <= 1'b0;
    else        sel_q[0] <= par_sel;
  end

  for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sel
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_q[g] <= 1'b0;
      else        sel_q[g] <= sel_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) par_q <= '0;
    else        par_q <= par_code;
  end

  assign src       = code_src_e'(sel_q[SYNC_STAGES-1]);
  assign len_code  = (src == SRC_PARALLEL) ? par_q : ser_code;
  assign delay_len = code_to_delay(len_code);

  p_par_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_PARALLEL && $past(src == SRC_PARALLEL)) |-> len_code == $past(par_code));

  p_ser_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_SERIAL && $past(src == SRC_SERIAL) && !ser_upd) |-> $stable(len_code));

endmodule

// File: rtl/serial_len_loader.sv
module serial_len_loader #(
  parameter int CODE_W      = 11,
  parameter int BASE_DELAY  = 31,
  parameter int SYNC_STAGES = 2,
  localparam int DLY_W      = $clog2(BASE_DELAY + (1 << CODE_W))
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sdata,
  input  logic              latch_en,
  input  logic              par_sel,
  input  logic [CODE_W-1:0] par_code,
  output logic [CODE_W-1:0] len_code,
  output logic [DLY_W-1:0]  delay_len,
  output logic              code_upd
);

  logic [CODE_W-1:0] set_code;
  logic              set_tog;
  logic [CODE_W-1:0] ser_code;

  sll_shift_capture #(.CODE_W(CODE_W)) u_capture (
    .rst_n    (rst_n),
    .sclk     (sclk),
    .sdata    (sdata),
    .latch_en (latch_en),
    .set_code (set_code),
    .set_tog  (set_tog)
  );

  sll_code_sync #(.CODE_W(CODE_W), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_code (set_code),
    .set_tog  (set_tog),
    .code_q   (ser_code),
    .upd_q    (code_upd)
  );

  sll_mode_mux #(
    .CODE_W      (CODE_W),
    .BASE_DELAY  (BASE_DELAY),
    .SYNC_STAGES (SYNC_STAGES),
    .DLY_W       (DLY_W)
  ) u_mux (
    .clk       (clk),
    .rst_n     (rst_n),
    .par_sel   (par_sel),
    .par_code  (par_code),
    .ser_code  (ser_code),
    .ser_upd   (code_upd),
    .len_code  (len_code),
    .delay_len (delay_len)
  );

endmodule

// File: tb/serial_len_loader_tb.sv
module serial_len_loader_tb;
  localparam int CW = 11;
  localparam int DW = 12;

  logic clk = 0, rst_n = 0, sclk = 0, sdata = 0, latch_en = 0, par_sel = 0;
  logic [CW-1:0] par_code = '0;
  wire  [CW-1:0] len_code;
  wire  [DW-1:0] delay_len;
  wire           code_upd;

  serial_len_loader u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata(sdata), .latch_en(latch_en),
    .par_sel(par_sel), .par_code(par_code), .len_code(len_code),
    .delay_len(delay_len), .code_upd(code_upd)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { logic [CW-1:0] code; int due; bit cmp; } item_t;
  item_t sbq[$];
  int total = 0, bad = 0;
  bit done = 0;
  logic [CW-1:0] last_ser = '0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_delay(input int c);
    return c + 31;
  endfunction

  task automatic shift_bits(input logic [15:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdata = bits[i];
      #3 sclk = 1;
      #4 sclk = 0;
      #3;
    end
  endtask

  // Driver: push the expectation, strobe, confirm the old code survives one edge before due.
  task automatic latch_push(input logic [CW-1:0] code, input bit cmp);
    @(negedge clk);
    sbq.push_back('{code, cyc + 3, cmp});
    latch_en = 1;
    #3 latch_en = 0;
    repeat (2) @(negedge clk);
    if (cmp) check(len_code == last_ser, "R11 old code held", len_code, last_ser);
    repeat (4) @(negedge clk);
    last_ser = code;
  endtask

  // Monitor: every update pulse must match the head of the queue.
  always @(negedge clk) begin
    item_t it;
    if (rst_n && code_upd) begin
      if (sbq.size() == 0) check(0, "R6 unexpected update", 1, 0);
      else begin
        it = sbq.pop_front();
        check(cyc == it.due, "R5 update edge", cyc, it.due);
        if (it.cmp) begin
          check(len_code == it.code, "R2 R4 serial code", len_code, it.code);
          check(delay_len == ref_delay(it.code), "R9 delay length", delay_len, ref_delay(it.code));
        end
      end
    end
  end

  initial begin
    logic [15:0] long_bits;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(len_code == 0, "R1 reset code", len_code, 0);
    check(delay_len == 31, "R1 reset delay", delay_len, 31);
    check(code_upd == 0, "R1 reset pulse", code_upd, 0);

    // R2: several serial words, MSB first
    shift_bits(16'h0001, 11); latch_push(11'h001, 1);
    shift_bits(16'h0400, 11); latch_push(11'h400, 1);
    shift_bits(16'h07FF, 11); latch_push(11'h7FF, 1);
    shift_bits(16'h02B6, 11); latch_push(11'h2B6, 1);

    // R3: 14 bits, last 11 kept
    long_bits = 16'h3E5A;
    shift_bits(long_bits, 14); latch_push(long_bits[10:0], 1);

    // R4: shifting without a strobe changes nothing at the output
    shift_bits(16'h0123, 11);
    repeat (6) @(negedge clk);
    check(len_code == 11'h65A, "R4 no latch no change", len_code, 11'h65A);
    check(code_upd == 0, "R4 no pulse", code_upd, 0);
    latch_push(11'h123, 1);

    // R8: parallel bus ignored in serial mode
    for (int i = 1; i <= 5; i++) begin
      @(negedge clk) par_code = 11'(i * 397);
      @(negedge clk);
      check(len_code == 11'h123, "R8 par ignored", len_code, 11'h123);
    end

    // R7: parallel mode
    @(negedge clk); par_sel = 1; par_code = 11'h0AB;
    repeat (3) @(negedge clk);
    check(len_code == 11'h0AB, "R7 par select", len_code, 11'h0AB);
    par_code = 11'h7FF;
    @(negedge clk);
    check(len_code == 11'h7FF, "R7 par follows", len_code, 11'h7FF);
    check(delay_len == 2078, "R9 max delay", delay_len, 2078);

    // R10: strobe in parallel mode updates stored serial code
    shift_bits(16'h0055, 11); latch_push(11'h055, 0);
    check(len_code == 11'h7FF, "R10 par still shown", len_code, 11'h7FF);
    @(negedge clk); par_sel = 0;
    repeat (3) @(negedge clk);
    check(len_code == 11'h055, "R10 serial restored", len_code, 11'h055);

    check(sbq.size() == 0, "R6 all updates seen", sbq.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R5 actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule